// File: doc/BRIEF.md
# Masked BCD Time Alarm Comparator

This block watches a running calendar time, supplied from outside as six BCD fields (seconds, minutes, hours, day of week, day of month and month), and raises an alarm when that time matches a programmed target. Each of the six target fields is held in its own byte-wide register. The top bit of each register decides whether that field takes part in the comparison. A field whose compare bit is clear matches any time value. This lets software set alarms such as "every hour at minute 30" or "every Monday".

The time counters live outside the block. Once per second, after the counters have moved to the new value, the counter logic pulses a one-cycle tick. On that tick the block compares every enabled field. If all enabled fields are equal to the time, it sets a sticky alarm flag. The flag and an interrupt enable share one control register. Software clears the flag by writing 0 to its bit. The interrupt output is high while both the flag and the enable are set. A simple write port and a combinational read port give access to the registers.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, all six alarm registers read 0x00, the control register reads 0x00, and `alarm_irq` is 0.
- R2: The alarm registers sit at indices 8 to 13 in this order: seconds, minutes, hours, weekday, day of month, month. Each register reads back the full byte last written to it. Bit 7 is the compare enable. Bits 6:0 hold the BCD target. The month target uses the same 1 to 12 BCD coding as the month counter.
- R3: A field whose bit 7 is 0 matches any time value, so writing 0x00 to a register removes that field from the comparison.
- R4: In a cycle where `tick` is high, the flag is set if bits 6:0 of every enabled field equal bits 6:0 of the matching `time_bcd` field. The flag reads as 1 from the cycle after that clock edge. A mismatch in any one enabled field prevents the set.
- R5: The flag is never set in a cycle where `tick` is low, and it is never set when no field is enabled, whatever the time inputs are.
- R6: The control register is at index 14. Bit 0 is the alarm flag and bit 3 is the interrupt enable; its other bits read 0. A write of 0 to bit 0 clears the flag, and a write of 1 to bit 0 leaves the flag unchanged. Bit 3 takes the written value.
- R7: `alarm_irq` is 1 exactly while the flag and the interrupt enable are both 1.
- R8: If a flag-clearing write to the control register and a flag-setting match fall in the same cycle, the flag ends up set.
- R9: Writes to indices other than 8 to 14 change no register. Reads of those indices return 0x00.
- R10: Once set, the flag stays set through later ticks that do not match, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per second; `time_bcd` already holds the new time |
| time_bcd | input | 48 | Current time: byte k is field k (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read index |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
Register writes and the match taken on a `tick` both act at the clock edge where they are presented. Their effect on `rd_data` and `alarm_irq` is therefore due one cycle later, and `rd_data` follows `rd_addr` with no delay. The bench drives every stimulus just after a falling edge and waits through exactly one rising edge. It then reads the control register and the interrupt at the next falling edge. So each result is sampled in the first cycle it is due, and before the next stimulus can disturb it. A model in the bench applies the same edge rule: a match uses the register contents from before any write in that same cycle, and a set overrides a clear.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   // Field order inside the packed time vector and inside the register window.
   localparam int unsigned FLD_SEC  = 0;
   localparam int unsigned FLD_MIN  = 1;
   localparam int unsigned FLD_HOUR = 2;
   localparam int unsigned FLD_WDAY = 3;
   localparam int unsigned FLD_MDAY = 4;
   localparam int unsigned FLD_MON  = 5;
   localparam int unsigned FLD_COUNT = 6;

   // Decoded control-register write.
   typedef struct packed {
      logic sel;       // control register addressed by a write
      logic flag_keep; // written flag bit (0 clears, 1 keeps)
      logic ena_val;   // written interrupt-enable bit
   } ctrl_wr_t;

endpackage

// File: rtl/alarm_field.sv
module alarm_field #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned INDEX  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] cur_val,
   output logic [DATA_W-1:0] reg_q,
   output logic              cmp_en,
   output logic              cmp_ok
);
   localparam int unsigned VAL_W = DATA_W - 1;
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(INDEX);

   if (DATA_W < 2) begin : g_bad_width
      $error("alarm_field: DATA_W must leave room for an enable bit");
   end
   if (INDEX >= (1 << ADDR_W)) begin : g_bad_index
      $error("alarm_field: INDEX outside the address space");
   end

   logic hit_wr;
   assign hit_wr = wr_en && (wr_addr == MY_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_q <= '0;
      else if (hit_wr) reg_q <= wr_data;
   end

   assign cmp_en = reg_q[DATA_W-1];
   assign cmp_ok = !cmp_en || (reg_q[VAL_W-1:0] == cur_val[VAL_W-1:0]);

   // R3: a zero write leaves the field out of the comparison
   a_r3_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && wr_data == '0) |=> (!cmp_en && cmp_ok));

   // R2: a write lands in the register by the next cycle
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wr |=> (reg_q == $past(wr_data)));

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FLAG_BIT = 0,
   parameter int unsigned ENA_BIT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_wr_t          cwr,
   input  logic              set_req,
   output logic              flag_q,
   output logic              ena_q,
   output logic              irq,
   output logic [DATA_W-1:0] rdata
);
   if (FLAG_BIT >= DATA_W || ENA_BIT >= DATA_W || FLAG_BIT == ENA_BIT) begin : g_bad_bits
      $error("alarm_ctrl: flag and enable bits must be distinct and inside DATA_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ena_q  <= 1'b0;
      end else begin
         if (set_req)                         flag_q <= 1'b1;
         else if (cwr.sel && !cwr.flag_keep)  flag_q <= 1'b0;
         if (cwr.sel) ena_q <= cwr.ena_val;
      end
   end

   assign irq = flag_q & ena_q;

   always_comb begin
      rdata = '0;
      rdata[FLAG_BIT] = flag_q;
      rdata[ENA_BIT]  = ena_q;
   end

   // R4: a match sets the flag on the next cycle
   a_r4_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> flag_q);

   // R8: set beats a simultaneous clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && cwr.sel && !cwr.flag_keep) |=> flag_q);

   // R6: clearing write without a match drops the flag
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cwr.sel && !cwr.flag_keep && !set_req) |=> !flag_q);

   // R10: flag only falls after a clearing write
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(cwr.sel && !cwr.flag_keep));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_FIELDS = FLD_COUNT,
   parameter int unsigned ALARM_BASE = 8,
   parameter int unsigned CTRL_IDX   = 14,
   parameter int unsigned FLAG_BIT   = 0,
   parameter int unsigned ENA_BIT    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic [NUM_FIELDS*DATA_W-1:0] time_bcd,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         alarm_irq
);
   localparam int unsigned LAST_IDX = ALARM_BASE + NUM_FIELDS - 1;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_IDX);

   if (LAST_IDX >= (1 << ADDR_W) || CTRL_IDX >= (1 << ADDR_W)) begin : g_bad_map
      $error("rtc_alarm_cmp: register window exceeds ADDR_W");
   end
   if (CTRL_IDX >= ALARM_BASE && CTRL_IDX <= LAST_IDX) begin : g_bad_overlap
      $error("rtc_alarm_cmp: control index overlaps the alarm window");
   end
   if (NUM_FIELDS < 1) begin : g_bad_count
      $error("rtc_alarm_cmp: need at least one field");
   end

   logic [DATA_W-1:0]     fld_q [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] fld_en;
   logic [NUM_FIELDS-1:0] fld_ok;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      alarm_field #(
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W),
         .INDEX  (ALARM_BASE + g)
      ) u_field (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .cur_val (time_bcd[g*DATA_W +: DATA_W]),
         .reg_q   (fld_q[g]),
         .cmp_en  (fld_en[g]),
         .cmp_ok  (fld_ok[g])
      );
   end

   logic any_en;
   logic set_req;
   assign any_en  = |fld_en;
   assign set_req = tick && any_en && (&fld_ok);

   ctrl_wr_t          cwr;
   logic              flag_w;
   logic              ena_w;
   logic [DATA_W-1:0] ctrl_rd;

   assign cwr.sel       = wr_en && (wr_addr == CTRL_ADDR);
   assign cwr.flag_keep = wr_data[FLAG_BIT];
   assign cwr.ena_val   = wr_data[ENA_BIT];

   alarm_ctrl #(
      .DATA_W   (DATA_W),
      .FLAG_BIT (FLAG_BIT),
      .ENA_BIT  (ENA_BIT)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cwr     (cwr),
      .set_req (set_req),
      .flag_q  (flag_w),
      .ena_q   (ena_w),
      .irq     (alarm_irq),
      .rdata   (ctrl_rd)
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_FIELDS; k++) begin
         if (rd_addr == ADDR_W'(ALARM_BASE + k)) rd_data = fld_q[k];
      end
      if (rd_addr == CTRL_ADDR) rd_data = ctrl_rd;
   end

   // R5: the flag rises only after a tick
   a_r5_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_w) |-> $past(tick));

   // R5: a tick with every field disabled never raises the flag
   a_r5_no_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !any_en) |=> !$rose(flag_w));

   // R7: the interrupt needs both the flag and the enable
   a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> (flag_w && ena_w));

endmodule

// File: tb/rtc_alarm_cmp_test.sv
module rtc_alarm_cmp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [47:0] time_bcd = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        alarm_irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [7:0] m_alm [6];
   bit m_flag = 0;
   bit m_ena = 0;

   always #4 clk = ~clk;

   rtc_alarm_cmp uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .time_bcd(time_bcd),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .alarm_irq(alarm_irq)
   );

   function automatic bit model_hit(input logic [47:0] tm);
      bit any = 0;
      bit all = 1;
      for (int k = 0; k < 6; k++) begin
         if (m_alm[k][7]) begin
            any = 1;
            if (m_alm[k][6:0] != tm[k*8 +: 7]) all = 0;
         end
      end
      return any && all;
   endfunction

   function automatic logic [47:0] pack_time(input logic [7:0] s, mi, h, w, d, mo);
      return {mo, d, w, h, mi, s};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock cycle of stimulus, entered and left at a falling edge
   task automatic step(input bit w, input logic [3:0] a, input logic [7:0] d,
                       input bit t, input logic [47:0] tm);
      bit hit;
      wr_en = w; wr_addr = a; wr_data = d; tick = t; time_bcd = tm;
      @(posedge clk);
      hit = t && model_hit(tm);
      if (w && a == 4'd14) m_ena = d[3];
      if (hit) m_flag = 1;
      else if (w && a == 4'd14 && !d[0]) m_flag = 0;
      if (w && a >= 4'd8 && a <= 4'd13) m_alm[a - 4'd8] = d;
      @(negedge clk);
      wr_en = 0; tick = 0;
   endtask

   task automatic check_ctrl(input string tag);
      rd_addr = 4'd14;
      #1;
      check({tag, " ctrl"}, rd_data, {4'b0, m_ena, 2'b0, m_flag});
      check({tag, " irq"}, alarm_irq, m_flag & m_ena);
   endtask

   task automatic check_regs(input string tag);
      for (int k = 0; k < 6; k++) begin
         rd_addr = 4'(8 + k);
         #1;
         check(tag, rd_data, m_alm[k]);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] pick [3];
      void'($urandom(32'h0A1A_5EED));
      pick[0] = 8'h00; pick[1] = 8'h01; pick[2] = 8'h12;
      for (int k = 0; k < 6; k++) m_alm[k] = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check_regs("R1 reset alarm regs");
      check_ctrl("R1 reset");
      rd_addr = 4'd14; #1;
      check("R1 ctrl zero", rd_data, 8'h00);

      // R2 layout and read back
      step(1, 4'd8,  8'hD9, 0, '0);
      step(1, 4'd9,  8'hB0, 0, '0);
      step(1, 4'd10, 8'hA3, 0, '0);
      step(1, 4'd11, 8'h86, 0, '0);
      step(1, 4'd12, 8'hB1, 0, '0);
      step(1, 4'd13, 8'h92, 0, '0);
      check_regs("R2 readback");

      // R4 mismatch on month only: no set
      step(0, 4'd0, 8'h00, 1, pack_time(8'h59, 8'h30, 8'h23, 8'h06, 8'h31, 8'h11));
      check_ctrl("R4 one field differs");
      check("R4 flag clear after mismatch", rd_data[0], 1'b0);
      // R2/R4 full match including month 12
      step(0, 4'd0, 8'h00, 1, pack_time(8'h59, 8'h30, 8'h23, 8'h06, 8'h31, 8'h12));
      check_ctrl("R4 full match");
      check("R2 month 12 match sets flag", rd_data[0], 1'b1);

      // R6 write 1 to flag bit keeps it; R7 irq stays low without enable
      step(1, 4'd14, 8'h01, 0, '0);
      check_ctrl("R6 keep flag");
      check("R7 irq low without enable", alarm_irq, 1'b0);
      step(1, 4'd14, 8'h09, 0, '0);
      check("R7 irq with flag and enable", alarm_irq, 1'b1);
      // R10 sticky across non-matching tick
      step(0, 4'd0, 8'h00, 1, pack_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01));
      check_ctrl("R10 sticky");
      check("R10 flag held", rd_data[0], 1'b1);
      // R6 clear
      step(1, 4'd14, 8'h08, 0, '0);
      check_ctrl("R6 clear");
      check("R6 flag cleared", rd_data[0], 1'b0);
      check("R7 irq drops", alarm_irq, 1'b0);

      // R3 only seconds enabled
      step(1, 4'd8,  8'h85, 0, '0);
      for (int k = 9; k <= 13; k++) step(1, 4'(k), 8'h00, 0, '0);
      check_regs("R3 disabled regs read zero");
      // R5 no tick: no set
      step(0, 4'd0, 8'h00, 0, pack_time(8'h05, 8'h44, 8'h07, 8'h02, 8'h15, 8'h09));
      check_ctrl("R5 no tick");
      check("R5 flag stays low without tick", rd_data[0], 1'b0);
      step(0, 4'd0, 8'h00, 1, pack_time(8'h05, 8'h44, 8'h07, 8'h02, 8'h15, 8'h09));
      check_ctrl("R3 disabled fields match anything");
      check("R3 flag set", rd_data[0], 1'b1);
      check("R7 irq on set with enable", alarm_irq, 1'b1);

      // R8 set beats clear in the same cycle
      step(1, 4'd14, 8'h08, 1, pack_time(8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00));
      check_ctrl("R8 set wins");
      check("R8 flag", rd_data[0], 1'b1);
      step(1, 4'd14, 8'h00, 0, '0);
      check_ctrl("R6 clear and disable");

      // R5 all fields disabled
      step(1, 4'd8, 8'h00, 0, '0);
      step(0, 4'd0, 8'h00, 1, '0);
      check_ctrl("R5 no fields enabled");
      check("R5 flag low with no fields", rd_data[0], 1'b0);

      // R9 writes outside the map are ignored, reads return zero
      step(1, 4'd8, 8'hC2, 0, '0);
      step(1, 4'd3, 8'hFF, 0, '0);
      step(1, 4'd15, 8'hFF, 0, '0);
      step(1, 4'd7, 8'hFF, 0, '0);
      check_regs("R9 regs unchanged");
      check_ctrl("R9 ctrl unchanged");
      rd_addr = 4'd15; #1;
      check("R9 unmapped read", rd_data, 8'h00);
      rd_addr = 4'd3; #1;
      check("R9 unmapped read low", rd_data, 8'h00);

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int unsigned r = $urandom % 5;
         if (r == 0) begin
            logic [7:0] d = {1'($urandom), pick[$urandom % 3][6:0]};
            step(1, 4'(8 + $urandom % 6), d, 0, '0);
         end else if (r == 1) begin
            step(1, 4'd14, 8'($urandom), 0, '0);
         end else begin
            logic [47:0] tm;
            for (int k = 0; k < 6; k++)
               tm[k*8 +: 8] = {1'($urandom), pick[$urandom % 3][6:0]};
            step((r == 4), 4'd14, 8'($urandom), 1, tm);
         end
         check_ctrl("R4/R6/R8 random");
         if (i % 50 == 0) check_regs("R2 random readback");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule